// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block holds the two threshold offsets that a queue's programmable flags compare against: a lower offset for the almost-empty flag and an upper offset for the almost-full flag. Both offsets can be written in one of two ways. The first is bit-serial, one bit for each rising edge of a slow serial clock. The second is word-wide, through the queue's write data port, while a load select is held. Either offset can be read back word by word through the read data port.

The loading method is captured from a select input while master reset is high. Master reset returns both offsets to a default threshold. A partial reset leaves the offsets and the chosen method alone. It only clears the read-back word and restarts the load and read-back sequences. Everything runs in the one system clock domain. The serial clock is an ordinary input that is sampled on each system clock edge, and its rising edge is found from two successive samples.

Top module: `flag_offset_loader`

## Requirements
- R1: While `rst` is high at a clock edge, both offsets become `DEFAULT_OFS` (127 by default), `rd_data` becomes 0, all load and read-back sequences restart at the almost-empty offset, and the loading method is captured from `method_sel` (0 = serial, 1 = parallel).
- R2: In parallel mode, each edge with `wr_en` and `load_sel` both high writes `wr_data[OFS_W-1:0]`. The first such write goes to the almost-empty offset, the next to the almost-full offset, and the order then alternates. The new value is visible on the outputs after that edge.
- R3: A `wr_en` pulse with `load_sel` low leaves both offsets unchanged.
- R4: In serial mode, a serial rising edge with `ser_en` high stores `ser_din` into the next bit. A serial rising edge is an edge where `ser_clk` is sampled high after being sampled low on the previous edge. Bits fill the almost-empty offset from bit 0 up to bit `OFS_W-1`, then the almost-full offset from bit 0 up. After 2*`OFS_W` bits the order wraps to almost-empty bit 0.
- R5: A serial rising edge with `ser_en` low changes no offset and does not advance the serial position.
- R6: In serial mode, parallel writes leave the offsets and the parallel order untouched. In parallel mode, serial edges leave the offsets untouched.
- R7: Each edge with `rd_en` and `load_sel` both high loads `rd_data` with the almost-empty offset (first) or the almost-full offset (second), alternating and zero-extended, using the offset values from before that edge. At other edges `rd_data` holds its value.
- R8: A partial reset (`prst` high, `rst` low) keeps both offsets and the loading method. It clears `rd_data` to 0 and restarts the parallel, serial and read-back orders at the almost-empty offset.
- R9: `method_sel` has no effect outside master reset.
- R10: An `rd_en` pulse with `load_sel` low leaves `rd_data` and the read-back order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| method_sel | input | 1 | Loading method captured at master reset: 0 serial, 1 parallel |
| load_sel | input | 1 | Routes write and read port accesses to the offsets |
| ser_clk | input | 1 | Serial bit clock, sampled by `clk` |
| ser_en | input | 1 | Serial load enable |
| ser_din | input | 1 | Serial data bit |
| wr_en | input | 1 | Write port enable |
| wr_data | input | DATA_W | Write port data |
| rd_en | input | 1 | Read port enable |
| ae_offset | output | OFS_W | Almost-empty offset |
| af_offset | output | OFS_W | Almost-full offset |
| rd_data | output | DATA_W | Read-back word |

## Verification
On every cycle, the assertions check four things. A partial reset must not disturb the offsets. In serial mode, at most one offset bit may change per edge, and nothing may change while `ser_en` is low. In parallel mode, the offsets may change only when a selected write happens, and never both at once. `rd_data` must hold while no selected read occurs. The assertions cannot show that the right bit or word reached the right offset, that the alternating orders restart after each kind of reset, or that the serial order wraps. The bench's scenarios show these by comparing the outputs against an independent model on every clock.

// File: rtl/ofl_pkg.sv
package ofl_pkg;

    typedef enum logic {
        LOAD_SERIAL   = 1'b0,
        LOAD_PARALLEL = 1'b1
    } load_mode_e;

    // One write request against the offset pair
    typedef struct packed {
        logic en;
        logic to_full;   // 0: almost-empty offset, 1: almost-full offset
    } ofs_wr_t;

    function automatic int wrap_inc(input int cur, input int lim);
        return (cur + 1 >= lim) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/ofl_serial_ctrl.sv
module ofl_serial_ctrl
    import ofl_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     prst,
    input  logic                     active,
    input  logic                     ser_clk,
    input  logic                     ser_en,
    input  logic                     ser_din,
    output ofs_wr_t                  bit_wr,
    output logic [$clog2(OFS_W)-1:0] bit_pos,
    output logic                     bit_val
);
    localparam int TOTAL = 2 * OFS_W;
    localparam int CNT_W = $clog2(TOTAL);
    localparam int POS_W = $clog2(OFS_W);

    logic             sclk_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise;
    logic             in_full;

    assign rise    = ser_clk && !sclk_q && ser_en && active;
    assign in_full = (cnt_q >= CNT_W'(OFS_W));

    always_ff @(posedge clk) begin
        sclk_q <= ser_clk;
        if (rst || prst) begin
            cnt_q <= '0;
        end else if (rise) begin
            cnt_q <= CNT_W'(wrap_inc(int'(cnt_q), TOTAL));
        end
    end

    always_comb begin
        bit_wr.en      = rise;
        bit_wr.to_full = in_full;
        bit_pos        = in_full ? POS_W'(cnt_q - CNT_W'(OFS_W)) : POS_W'(cnt_q);
        bit_val        = ser_din;
    end

endmodule

// File: rtl/ofl_par_seq.sv
module ofl_par_seq
    import ofl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    prst,
    input  logic    req,
    output ofs_wr_t slot
);
    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst || prst) begin
            sel_q <= 1'b0;
        end else if (req) begin
            sel_q <= !sel_q;
        end
    end

    always_comb begin
        slot.en      = req;
        slot.to_full = sel_q;
    end

endmodule

// File: rtl/ofl_offset_regs.sv
module ofl_offset_regs
    import ofl_pkg::*;
#(
    parameter int OFS_W       = 8,
    parameter int DEFAULT_OFS = 127
) (
    input  logic                     clk,
    input  logic                     rst,
    input  ofs_wr_t                  word_wr,
    input  logic [OFS_W-1:0]         word_val,
    input  ofs_wr_t                  bit_wr,
    input  logic [$clog2(OFS_W)-1:0] bit_pos,
    input  logic                     bit_val,
    output logic [OFS_W-1:0]         ae_q,
    output logic [OFS_W-1:0]         af_q
);
    localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(DEFAULT_OFS);

    // Partial reset deliberately absent: offsets survive it
    always_ff @(posedge clk) begin
        if (rst) begin
            ae_q <= RST_VAL;
            af_q <= RST_VAL;
        end else begin
            if (word_wr.en) begin
                if (word_wr.to_full) af_q <= word_val;
                else                 ae_q <= word_val;
            end
            if (bit_wr.en) begin
                if (bit_wr.to_full) af_q[bit_pos] <= bit_val;
                else                ae_q[bit_pos] <= bit_val;
            end
        end
    end

endmodule

// File: rtl/ofl_readback.sv
module ofl_readback
    import ofl_pkg::*;
#(
    parameter int OFS_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prst,
    input  logic              req,
    input  logic [OFS_W-1:0]  ae,
    input  logic [OFS_W-1:0]  af,
    output logic [DATA_W-1:0] data_q
);
    ofs_wr_t slot;

    ofl_par_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .prst (prst),
        .req  (req),
        .slot (slot)
    );

    always_ff @(posedge clk) begin
        if (rst || prst) begin
            data_q <= '0;
        end else if (slot.en) begin
            data_q <= DATA_W'(slot.to_full ? af : ae);
        end
    end

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
    import ofl_pkg::*;
#(
    parameter int OFS_W       = 8,
    parameter int DATA_W      = 16,
    parameter int DEFAULT_OFS = 127
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prst,
    input  logic              method_sel,
    input  logic              load_sel,
    input  logic              ser_clk,
    input  logic              ser_en,
    input  logic              ser_din,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [OFS_W-1:0]  ae_offset,
    output logic [OFS_W-1:0]  af_offset,
    output logic [DATA_W-1:0] rd_data
);
    localparam int POS_W = $clog2(OFS_W);

    load_mode_e       mode_q;
    ofs_wr_t          word_wr;
    ofs_wr_t          bit_wr;
    logic [POS_W-1:0] bit_pos;
    logic             bit_val;
    logic             par_req;
    logic             rd_req;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= load_mode_e'(method_sel);
    end

    assign par_req = wr_en && load_sel && (mode_q == LOAD_PARALLEL);
    assign rd_req  = rd_en && load_sel;

    ofl_par_seq u_wseq (
        .clk  (clk),
        .rst  (rst),
        .prst (prst),
        .req  (par_req),
        .slot (word_wr)
    );

    ofl_serial_ctrl #(.OFS_W(OFS_W)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .prst    (prst),
        .active  (mode_q == LOAD_SERIAL),
        .ser_clk (ser_clk),
        .ser_en  (ser_en),
        .ser_din (ser_din),
        .bit_wr  (bit_wr),
        .bit_pos (bit_pos),
        .bit_val (bit_val)
    );

    ofl_offset_regs #(.OFS_W(OFS_W), .DEFAULT_OFS(DEFAULT_OFS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .word_wr  (ofs_wr_t'{en: word_wr.en && !prst, to_full: word_wr.to_full}),
        .word_val (wr_data[OFS_W-1:0]),
        .bit_wr   (ofs_wr_t'{en: bit_wr.en && !prst, to_full: bit_wr.to_full}),
        .bit_pos  (bit_pos),
        .bit_val  (bit_val),
        .ae_q     (ae_offset),
        .af_q     (af_offset)
    );

    ofl_readback #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rb (
        .clk    (clk),
        .rst    (rst),
        .prst   (prst),
        .req    (rd_req),
        .ae     (ae_offset),
        .af     (af_offset),
        .data_q (rd_data)
    );

endmodule

// File: rtl/ofl_checker.sv
module ofl_checker
    import ofl_pkg::*;
#(
    parameter int OFS_W       = 8,
    parameter int DATA_W      = 16,
    parameter int DEFAULT_OFS = 127
) (
    input logic              clk,
    input logic              rst,
    input logic              prst,
    input logic              load_sel,
    input logic              wr_en,
    input logic              rd_en,
    input logic              ser_en,
    input load_mode_e        mode_q,
    input logic [OFS_W-1:0]  ae_offset,
    input logic [OFS_W-1:0]  af_offset,
    input logic [DATA_W-1:0] rd_data
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always @(negedge clk) begin
        if (rst_q) begin
            reset_values_chk: assert (ae_offset == OFS_W'(DEFAULT_OFS) &&
                                      af_offset == OFS_W'(DEFAULT_OFS) && rd_data == '0)
                else $error("offsets or read word not at reset value");
        end
    end

    // R8
    prst_keeps_offsets_chk: assert property (@(posedge clk) disable iff (rst)
        prst |=> (ae_offset == $past(ae_offset) && af_offset == $past(af_offset) && rd_data == '0));

    // R4
    serial_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == LOAD_SERIAL) |=>
            ($countones({ae_offset, af_offset} ^ $past({ae_offset, af_offset})) <= 1));

    // R5
    serial_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == LOAD_SERIAL && !ser_en) |=> ($stable(ae_offset) && $stable(af_offset)));

    // R6
    parallel_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == LOAD_PARALLEL && !(wr_en && load_sel)) |=>
            ($stable(ae_offset) && $stable(af_offset)));

    // R2
    parallel_single_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == LOAD_PARALLEL) |=> !(!$stable(ae_offset) && !$stable(af_offset)));

    // R10
    readback_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(rd_en && load_sel) && !prst) |=> $stable(rd_data));

endmodule

bind flag_offset_loader ofl_checker #(
    .OFS_W(OFS_W), .DATA_W(DATA_W), .DEFAULT_OFS(DEFAULT_OFS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .prst      (prst),
    .load_sel  (load_sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .ser_en    (ser_en),
    .mode_q    (mode_q),
    .ae_offset (ae_offset),
    .af_offset (af_offset),
    .rd_data   (rd_data)
);

// File: tb/flag_offset_loader_test.sv
module flag_offset_loader_test;
    localparam int OFS_W  = 8;
    localparam int DATA_W = 16;
    localparam int DEF    = 127;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic rst = 1'b1, prst = 1'b0, method_sel = 1'b1, load_sel = 1'b0;
    logic ser_clk = 1'b0, ser_en = 1'b0, ser_din = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [OFS_W-1:0]  ae_offset, af_offset;
    logic [DATA_W-1:0] rd_data;

    flag_offset_loader #(.OFS_W(OFS_W), .DATA_W(DATA_W), .DEFAULT_OFS(DEF)) uut (
        .clk(clk), .rst(rst), .prst(prst), .method_sel(method_sel), .load_sel(load_sel),
        .ser_clk(ser_clk), .ser_en(ser_en), .ser_din(ser_din), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .ae_offset(ae_offset), .af_offset(af_offset),
        .rd_data(rd_data)
    );

    int checks = 0, errors = 0, cycles = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference model
    int m_ae, m_af, m_rd, m_widx, m_sidx, m_ridx;
    bit m_par, m_sprev;

    task automatic model_update();
        int old_ae = m_ae, old_af = m_af;
        if (rst) begin
            m_ae = DEF; m_af = DEF; m_rd = 0; m_widx = 0; m_sidx = 0; m_ridx = 0;
            m_par = method_sel;
        end else if (prst) begin
            m_rd = 0; m_widx = 0; m_sidx = 0; m_ridx = 0;
        end else begin
            if (m_par && wr_en && load_sel) begin
                if (m_widx == 0) m_ae = wr_data[OFS_W-1:0];
                else             m_af = wr_data[OFS_W-1:0];
                m_widx = 1 - m_widx;
            end
            if (!m_par && ser_clk && !m_sprev && ser_en) begin
                if (m_sidx < OFS_W) begin
                    if (ser_din) m_ae = m_ae | (1 << m_sidx);
                    else         m_ae = m_ae & ~(1 << m_sidx);
                end else begin
                    if (ser_din) m_af = m_af | (1 << (m_sidx - OFS_W));
                    else         m_af = m_af & ~(1 << (m_sidx - OFS_W));
                end
                m_sidx = (m_sidx + 1) % (2 * OFS_W);
            end
            if (rd_en && load_sel) begin
                m_rd = (m_ridx == 0) ? old_ae : old_af;
                m_ridx = 1 - m_ridx;
            end
        end
        m_sprev = ser_clk;
    endtask

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check("ae_offset", int'(ae_offset), m_ae);
        check("af_offset", int'(af_offset), m_af);
        check("rd_data",   int'(rd_data),   m_rd);
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; load_sel = 0; ser_en = 0; ser_clk = 0; prst = 0;
    endtask

    task automatic par_write(input logic sel, input int v);
        idle(); load_sel = sel; wr_en = 1; wr_data = DATA_W'(v); step();
    endtask

    task automatic read_back(input logic sel);
        idle(); load_sel = sel; rd_en = 1; step();
    endtask

    task automatic ser_bit(input logic en, input logic b);
        idle(); step();
        ser_clk = 1; ser_en = en; ser_din = b; step();
        ser_clk = 1; ser_en = en; step();   // level held: no second edge
    endtask

    task automatic do_reset(input logic meth);
        idle(); rst = 1; method_sel = meth; step(); step(); rst = 0; step();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cur_req = "R1"; do_reset(1'b1);
        check("reset ae R1", int'(ae_offset), DEF);

        cur_req = "R2";
        par_write(1, 8'h15); par_write(1, 8'hC3); par_write(1, 8'h5A);
        check("ae after third write R2", int'(ae_offset), 8'h5A);
        par_write(1, 16'hFF81);

        cur_req = "R3"; par_write(0, 8'h00); par_write(0, 8'h77);

        cur_req = "R7"; read_back(1); read_back(1); read_back(1);
        cur_req = "R10"; read_back(0); idle(); step();

        cur_req = "R6"; ser_bit(1, 0); ser_bit(1, 1);

        cur_req = "R9"; method_sel = 0; par_write(1, 8'h22); method_sel = 1;

        cur_req = "R8";
        read_back(1);
        idle(); prst = 1; step(); idle();
        check("rd cleared R8", int'(rd_data), 0);
        par_write(1, 8'h44);    // sequence restarted: lands in almost-empty
        read_back(1);

        cur_req = "R4"; do_reset(1'b0);
        for (int i = 0; i < 2 * OFS_W; i++) ser_bit(1, logic'((16'hA5C3 >> i) & 1));
        check("ae serial R4", int'(ae_offset), 8'hC3);
        check("af serial R4", int'(af_offset), 8'hA5);
        ser_bit(1, 0); ser_bit(1, 0);   // wrap into almost-empty bits 0,1

        cur_req = "R5"; ser_bit(0, 1); ser_bit(0, 1);
        cur_req = "R6"; par_write(1, 8'h11); par_write(1, 8'h99);
        cur_req = "R7"; read_back(1); read_back(1);

        cur_req = "R8"; ser_bit(1, 1); idle(); prst = 1; step(); idle();
        ser_bit(1, 1);
        check("ae bit0 restart R8", int'(ae_offset) & 1, 1);

        cur_req = "R1"; do_reset(1'b1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule